// File: doc/BRIEF.md
# Register Redirection Table

This block sits at instruction issue and reinterprets the 5-bit register fields of a decoded instruction. Software-visible configuration entries each name a register in either the integer or the floating-point file. They mark that register as a vector and give it a starting physical register, an element width code and a packed-SIMD flag. From these entries the block builds two 32-slot lookup tables, one per register file. Every instruction then looks up its operand fields (destination and two sources) in the table for its register file.

For each operand the response carries the substituted register number, the vector flag, the element width code and the packed flag. A single all-scalar bit tells issue logic that no used operand is a vector, so the instruction can take the ordinary scalar path without any element loop. Any configuration write starts a rebuild of both tables. While the rebuild runs, a busy flag is raised and lookups are held off.

Top module: `reg_redirect_table`

## Requirements
- R1: After reset the block is idle (`busy` = 0, `rsp_valid` = 0). Every register looks up as itself with vector flag 0, width code 0, packed flag 0, and the all-scalar bit set.
- R2: An entry carries a type bit (0 = integer table, 1 = FP table), a key register, a starting register, a 2-bit width code (0 default, 1 half of default, 2 = 8-bit, 3 = 16-bit), a vector bit and a packed bit. The width code and packed bit of the slot are returned unchanged.
- R3: When the looked-up slot has its vector bit set, the response register is the slot's starting register.
- R4: When the slot is not a vector, or was never written, the response register equals the original field value.
- R5: `lk_is_fp` selects the table, and an entry only affects lookups in the table named by its type bit.
- R6: When two entries share type and key, the one at the higher entry index wins. Distinct keys may point at the same starting register.
- R7: The bank bit of a write is ignored: an entry written with bank 1 behaves exactly as with bank 0.
- R8: A lookup accepted at a clock edge (`lk_valid` with `lk_ready`) produces `rsp_valid` and its results at that edge, so results appear one cycle after the request is presented. An unaccepted cycle gives `rsp_valid` = 0.
- R9: `rsp_scalar` is 1 exactly when no operand with its `lk_used` bit set is a vector. Unused operands still report their own lookup fields.
- R10: A configuration write makes `busy` high for exactly NUM_ENTRIES+1 cycles: one clear cycle, then one cycle per entry. During that time `lk_ready` is 0 and no response is produced.
- R11: A write during a rebuild restarts it, so `busy` stays high for a further NUM_ENTRIES+1 cycles, and the later write is in effect when busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write one configuration entry |
| cfg_idx | input | IDX_W | Entry index (higher wins) |
| cfg_is_fp | input | 1 | Entry type: 0 integer, 1 FP |
| cfg_key | input | REG_W | Architectural register redirected |
| cfg_base | input | REG_W | Starting physical register |
| cfg_width | input | 2 | Element width code |
| cfg_vec | input | 1 | Vector flag |
| cfg_packed | input | 1 | Packed-SIMD flag |
| cfg_bank | input | 1 | Reserved bank bit (ignored) |
| busy | output | 1 | Table rebuild in progress |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup can be accepted |
| lk_is_fp | input | 1 | Use FP table |
| lk_regs | input | NUM_OPS*REG_W | Operand fields, operand i at bits [i*REG_W +: REG_W] |
| lk_used | input | NUM_OPS | Operand i present in the instruction |
| rsp_valid | output | 1 | Response valid |
| rsp_regs | output | NUM_OPS*REG_W | Redirected registers |
| rsp_vec | output | NUM_OPS | Vector flags |
| rsp_width | output | NUM_OPS*2 | Width codes, operand i at bits [2*i +: 2] |
| rsp_packed | output | NUM_OPS | Packed flags |
| rsp_scalar | output | 1 | No used operand is a vector |

## Verification
The bench builds the block with its default parameters: sixteen entries, three operand fields and 32-slot tables. With sixteen entries the full rebuild length of seventeen busy cycles is measured exactly, and entry indices far enough apart are available to show that a higher index overrides a lower one on the same key. Three operand fields are enough to mix vector, scalar and unused operands in a single lookup, which exercises the all-scalar decision with and without masking.

// File: rtl/rrt_pkg.sv
package rrt_pkg;
    parameter int RRT_REG_W = 5;

    typedef enum logic [1:0] {
        EW_DEFAULT = 2'd0,
        EW_HALF    = 2'd1,
        EW_8       = 2'd2,
        EW_16      = 2'd3
    } elw_e;

    typedef struct packed {
        logic                 vec;
        logic                 pk;
        elw_e                 width;
        logic [RRT_REG_W-1:0] base;
    } slot_t;

    typedef struct packed {
        logic                 valid;
        logic                 is_fp;
        logic [RRT_REG_W-1:0] key;
        slot_t                slot;
    } entry_t;

    typedef enum logic [1:0] {
        RB_IDLE  = 2'd0,
        RB_CLEAR = 2'd1,
        RB_FILL  = 2'd2
    } rb_state_e;
endpackage

// File: rtl/rrt_entry_store.sv
module rrt_entry_store
    import rrt_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic                          wr_is_fp,
    input  logic [RRT_REG_W-1:0]          wr_key,
    input  slot_t                         wr_slot,
    output entry_t [NUM_ENTRIES-1:0]      ents
);
    typedef struct packed {
        entry_t [NUM_ENTRIES-1:0] ent;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ent[wr_idx].valid = 1'b1;
            st_d.ent[wr_idx].is_fp = wr_is_fp;
            st_d.ent[wr_idx].key   = wr_key;
            st_d.ent[wr_idx].slot  = wr_slot;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ents = st_q.ent;

    // written entry is marked present on the following cycle (R2)
    p_entry_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ents[$past(wr_idx)].valid);
endmodule

// File: rtl/rrt_rebuild.sv
module rrt_rebuild
    import rrt_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    localparam int NUM_SLOTS = 2 ** RRT_REG_W,
    localparam int CNT_W = $clog2(NUM_ENTRIES),
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_ENTRIES - 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  entry_t [NUM_ENTRIES-1:0]  ents,
    output slot_t  [NUM_SLOTS-1:0]    int_tbl,
    output slot_t  [NUM_SLOTS-1:0]    fp_tbl,
    output logic                      busy
);
    typedef struct packed {
        rb_state_e                st;
        logic [CNT_W-1:0]         cnt;
        slot_t [NUM_SLOTS-1:0]    itbl;
        slot_t [NUM_SLOTS-1:0]    ftbl;
    } rb_t;

    rb_t rb_d, rb_q;
    entry_t cur;

    always_comb begin
        rb_d = rb_q;
        cur  = ents[rb_q.cnt];
        case (rb_q.st)
            RB_CLEAR: begin
                rb_d.itbl = '0;
                rb_d.ftbl = '0;
                rb_d.cnt  = '0;
                rb_d.st   = RB_FILL;
            end
            RB_FILL: begin
                if (cur.valid) begin
                    if (cur.is_fp) rb_d.ftbl[cur.key] = cur.slot;
                    else           rb_d.itbl[cur.key] = cur.slot;
                end
                if (rb_q.cnt == LAST) rb_d.st = RB_IDLE;
                else                  rb_d.cnt = rb_q.cnt + 1'b1;
            end
            default: ;
        endcase
        if (start) begin
            rb_d.st  = RB_CLEAR;
            rb_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rb_q <= '0;
        else        rb_q <= rb_d;
    end

    assign int_tbl = rb_q.itbl;
    assign fp_tbl  = rb_q.ftbl;
    assign busy    = (rb_q.st != RB_IDLE);

    // a write always opens a rebuild window (R10)
    p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    // a rebuild restarted mid-way begins again with a clear (R11)
    p_restart_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (rb_q.st == RB_CLEAR));
    // idle without a write stays idle
    p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy);
endmodule

// File: rtl/rrt_lookup.sv
module rrt_lookup
    import rrt_pkg::*;
#(
    parameter int NUM_OPS = 3,
    localparam int NUM_SLOTS = 2 ** RRT_REG_W
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               busy,
    input  slot_t [NUM_SLOTS-1:0]              int_tbl,
    input  slot_t [NUM_SLOTS-1:0]              fp_tbl,
    input  logic                               req_valid,
    input  logic                               req_is_fp,
    input  logic [NUM_OPS-1:0][RRT_REG_W-1:0]  req_regs,
    input  logic [NUM_OPS-1:0]                 req_used,
    output logic                               out_valid,
    output logic [NUM_OPS-1:0][RRT_REG_W-1:0]  out_regs,
    output logic [NUM_OPS-1:0]                 out_vec,
    output logic [NUM_OPS-1:0][1:0]            out_width,
    output logic [NUM_OPS-1:0]                 out_pk,
    output logic                               out_scalar
);
    typedef struct packed {
        logic                              valid;
        logic [NUM_OPS-1:0][RRT_REG_W-1:0] regs;
        logic [NUM_OPS-1:0]                vec;
        logic [NUM_OPS-1:0][1:0]           width;
        logic [NUM_OPS-1:0]                pk;
        logic                              scalar;
    } lk_t;

    lk_t lk_d, lk_q;
    slot_t [NUM_OPS-1:0] hit;

    generate
        for (genvar g = 0; g < NUM_OPS; g++) begin : g_sel
            assign hit[g] = req_is_fp ? fp_tbl[req_regs[g]] : int_tbl[req_regs[g]];
        end
    endgenerate

    always_comb begin
        lk_d       = lk_q;
        lk_d.valid = req_valid && !busy;
        if (req_valid && !busy) begin
            lk_d.scalar = 1'b1;
            for (int i = 0; i < NUM_OPS; i++) begin
                lk_d.regs[i]  = hit[i].vec ? hit[i].base : req_regs[i];
                lk_d.vec[i]   = hit[i].vec;
                lk_d.width[i] = hit[i].width;
                lk_d.pk[i]    = hit[i].pk;
                if (hit[i].vec && req_used[i]) lk_d.scalar = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lk_q <= '{default: '0, scalar: 1'b1};
        else        lk_q <= lk_d;
    end

    assign out_valid  = lk_q.valid;
    assign out_regs   = lk_q.regs;
    assign out_vec    = lk_q.vec;
    assign out_width  = lk_q.width;
    assign out_pk     = lk_q.pk;
    assign out_scalar = lk_q.scalar;

    // response only follows an accepted request (R8)
    p_resp_follows_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(req_valid) && !$past(busy)));
    // no response while the tables are rebuilt (R10)
    p_stall_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !out_valid);
    // all-scalar never claimed with a used vector operand (R9)
    p_scalar_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_scalar) |-> ((out_vec & $past(req_used)) == '0));

    generate
        for (genvar g = 0; g < NUM_OPS; g++) begin : g_chk
            // non-vector operands pass their field through (R4)
            p_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && !out_vec[g]) |-> (out_regs[g] == $past(req_regs[g])));
        end
    endgenerate
endmodule

// File: rtl/reg_redirect_table.sv
module reg_redirect_table
    import rrt_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int NUM_OPS     = 3,
    localparam int REG_W      = RRT_REG_W,
    localparam int IDX_W      = $clog2(NUM_ENTRIES),
    localparam int NUM_SLOTS  = 2 ** REG_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [IDX_W-1:0]         cfg_idx,
    input  logic                     cfg_is_fp,
    input  logic [REG_W-1:0]         cfg_key,
    input  logic [REG_W-1:0]         cfg_base,
    input  logic [1:0]               cfg_width,
    input  logic                     cfg_vec,
    input  logic                     cfg_packed,
    input  logic                     cfg_bank,
    output logic                     busy,
    input  logic                     lk_valid,
    output logic                     lk_ready,
    input  logic                     lk_is_fp,
    input  logic [NUM_OPS*REG_W-1:0] lk_regs,
    input  logic [NUM_OPS-1:0]       lk_used,
    output logic                     rsp_valid,
    output logic [NUM_OPS*REG_W-1:0] rsp_regs,
    output logic [NUM_OPS-1:0]       rsp_vec,
    output logic [NUM_OPS*2-1:0]     rsp_width,
    output logic [NUM_OPS-1:0]       rsp_packed,
    output logic                     rsp_scalar
);
    entry_t [NUM_ENTRIES-1:0] ents;
    slot_t  [NUM_SLOTS-1:0]   int_tbl;
    slot_t  [NUM_SLOTS-1:0]   fp_tbl;
    slot_t                    wr_slot;
    logic                     unused_bank;

    logic [NUM_OPS-1:0][REG_W-1:0] req_regs;
    logic [NUM_OPS-1:0][REG_W-1:0] out_regs;
    logic [NUM_OPS-1:0][1:0]       out_width;

    // reserved bank value carries no meaning here
    assign unused_bank = cfg_bank;

    assign wr_slot.vec   = cfg_vec;
    assign wr_slot.pk    = cfg_packed;
    assign wr_slot.width = elw_e'(cfg_width);
    assign wr_slot.base  = cfg_base;

    assign req_regs  = lk_regs;
    assign rsp_regs  = out_regs;
    assign rsp_width = out_width;
    assign lk_ready  = !busy;

    rrt_entry_store #(.NUM_ENTRIES(NUM_ENTRIES)) store_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_is_fp(cfg_is_fp),
        .wr_key(cfg_key), .wr_slot(wr_slot), .ents(ents)
    );

    rrt_rebuild #(.NUM_ENTRIES(NUM_ENTRIES)) rebuild_i (
        .clk(clk), .rst_n(rst_n), .start(cfg_we), .ents(ents),
        .int_tbl(int_tbl), .fp_tbl(fp_tbl), .busy(busy)
    );

    rrt_lookup #(.NUM_OPS(NUM_OPS)) lookup_i (
        .clk(clk), .rst_n(rst_n), .busy(busy),
        .int_tbl(int_tbl), .fp_tbl(fp_tbl),
        .req_valid(lk_valid), .req_is_fp(lk_is_fp),
        .req_regs(req_regs), .req_used(lk_used),
        .out_valid(rsp_valid), .out_regs(out_regs), .out_vec(rsp_vec),
        .out_width(out_width), .out_pk(rsp_packed), .out_scalar(rsp_scalar)
    );
endmodule

// File: tb/reg_redirect_table_tb_top.sv
`timescale 1ns/1ps
module reg_redirect_table_tb_top;
    localparam int NE = 16;
    localparam int NO = 3;
    localparam int RW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0, cfg_is_fp = 1'b0, cfg_vec = 1'b0, cfg_packed = 1'b0, cfg_bank = 1'b0;
    logic [3:0] cfg_idx = '0;
    logic [RW-1:0] cfg_key = '0, cfg_base = '0;
    logic [1:0] cfg_width = '0;
    logic busy, lk_ready, rsp_valid, rsp_scalar;
    logic lk_valid = 1'b0, lk_is_fp = 1'b0;
    logic [NO*RW-1:0] lk_regs = '0;
    logic [NO-1:0] lk_used = '0;
    logic [NO*RW-1:0] rsp_regs;
    logic [NO-1:0] rsp_vec, rsp_packed;
    logic [NO*2-1:0] rsp_width;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    reg_redirect_table #(.NUM_ENTRIES(NE), .NUM_OPS(NO)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_is_fp(cfg_is_fp), .cfg_key(cfg_key), .cfg_base(cfg_base),
        .cfg_width(cfg_width), .cfg_vec(cfg_vec), .cfg_packed(cfg_packed),
        .cfg_bank(cfg_bank), .busy(busy), .lk_valid(lk_valid), .lk_ready(lk_ready),
        .lk_is_fp(lk_is_fp), .lk_regs(lk_regs), .lk_used(lk_used),
        .rsp_valid(rsp_valid), .rsp_regs(rsp_regs), .rsp_vec(rsp_vec),
        .rsp_width(rsp_width), .rsp_packed(rsp_packed), .rsp_scalar(rsp_scalar)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // write one entry and return the number of busy cycles that follow
    task automatic wr(input int idx, input bit fp, input int key, input int base,
                      input int w, input bit vec, input bit pk, input bit bank,
                      output int nbusy);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_is_fp = fp; cfg_key = RW'(key);
        cfg_base = RW'(base); cfg_width = 2'(w); cfg_vec = vec; cfg_packed = pk;
        cfg_bank = bank;
        @(negedge clk);
        cfg_we = 1'b0; cfg_bank = 1'b0;
        nbusy = 0;
        while (busy) begin
            nbusy++;
            if (lk_ready) nbusy += 1000;
            @(negedge clk);
        end
    endtask

    task automatic wr_q(input int idx, input bit fp, input int key, input int base,
                        input int w, input bit vec, input bit pk);
        int nb;
        wr(idx, fp, key, base, w, vec, pk, 1'b0, nb);
    endtask

    task automatic look(input bit fp, input int r0, input int r1, input int r2,
                        input int used);
        @(negedge clk);
        lk_valid = 1'b1; lk_is_fp = fp; lk_used = 3'(used);
        lk_regs = {RW'(r2), RW'(r1), RW'(r0)};
        @(negedge clk);
        lk_valid = 1'b0;
        check("R8 response valid", int'(rsp_valid), 1);
    endtask

    function automatic int reg_of(int i);
        return int'(rsp_regs[i*RW +: RW]);
    endfunction
    function automatic int w_of(int i);
        return int'(rsp_width[i*2 +: 2]);
    endfunction

    task automatic t_reset;
        check("R1 busy after reset", int'(busy), 0);
        check("R1 rsp_valid after reset", int'(rsp_valid), 0);
        look(1'b0, 3, 4, 5, 7);
        check("R1 reg0", reg_of(0), 3);
        check("R1 reg2", reg_of(2), 5);
        check("R1 vec", int'(rsp_vec), 0);
        check("R1 width", int'(rsp_width), 0);
        check("R1 packed", int'(rsp_packed), 0);
        check("R1 scalar", int'(rsp_scalar), 1);
        @(negedge clk);
        check("R8 no response without request", int'(rsp_valid), 0);
    endtask

    task automatic t_vector;
        int nb;
        wr(0, 1'b0, 10, 20, 2, 1'b1, 1'b1, 1'b0, nb);
        check("R10 busy length", nb, NE + 1);
        look(1'b0, 10, 11, 10, 7);
        check("R3 reg0 redirected", reg_of(0), 20);
        check("R4 reg1 passes", reg_of(1), 11);
        check("R3 reg2 redirected", reg_of(2), 20);
        check("R3 vec flags", int'(rsp_vec), 5);
        check("R2 width code 8-bit", w_of(0), 2);
        check("R2 packed flag", int'(rsp_packed), 5);
        check("R9 not scalar", int'(rsp_scalar), 0);
    endtask

    task automatic t_nonvec;
        wr_q(1, 1'b0, 11, 30, 3, 1'b0, 1'b0);
        look(1'b0, 11, 1, 2, 7);
        check("R4 non-vector keeps reg", reg_of(0), 11);
        check("R2 width code 16-bit", w_of(0), 3);
        check("R4 vec clear", int'(rsp_vec), 0);
        check("R9 scalar", int'(rsp_scalar), 1);
    endtask

    task automatic t_fp;
        look(1'b1, 10, 0, 0, 1);
        check("R5 fp table untouched", reg_of(0), 10);
        check("R5 fp vec clear", int'(rsp_vec[0]), 0);
        wr_q(2, 1'b1, 10, 5, 1, 1'b1, 1'b0);
        look(1'b1, 10, 0, 0, 1);
        check("R5 fp redirect", reg_of(0), 5);
        check("R2 width code half", w_of(0), 1);
        look(1'b0, 10, 0, 0, 1);
        check("R5 int kept", reg_of(0), 20);
    endtask

    task automatic t_priority;
        wr_q(3, 1'b0, 10, 7, 0, 1'b1, 1'b0);
        look(1'b0, 10, 0, 0, 1);
        check("R6 higher index wins", reg_of(0), 7);
        wr_q(0, 1'b0, 10, 9, 0, 1'b1, 1'b0);
        look(1'b0, 10, 0, 0, 1);
        check("R6 lower rewrite loses", reg_of(0), 7);
        wr_q(5, 1'b0, 13, 7, 0, 1'b1, 1'b0);
        look(1'b0, 10, 13, 0, 3);
        check("R6 overlap key a", reg_of(0), 7);
        check("R6 overlap key b", reg_of(1), 7);
    endtask

    task automatic t_used;
        look(1'b0, 10, 1, 2, 6);
        check("R9 unused vector ignored", int'(rsp_scalar), 1);
        check("R9 unused still reports vec", int'(rsp_vec), 1);
        look(1'b0, 1, 2, 10, 4);
        check("R9 used vector in slot 2", int'(rsp_scalar), 0);
    endtask

    task automatic t_bank;
        int nb;
        wr(4, 1'b0, 12, 15, 2, 1'b1, 1'b0, 1'b1, nb);
        check("R7 bank write rebuild", nb, NE + 1);
        look(1'b0, 12, 0, 0, 1);
        check("R7 bank ignored reg", reg_of(0), 15);
        check("R7 bank ignored vec", int'(rsp_vec[0]), 1);
        check("R7 bank ignored width", w_of(0), 2);
    endtask

    task automatic t_stall;
        int nb;
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 4'd6; cfg_is_fp = 1'b0; cfg_key = 5'd14;
        cfg_base = 5'd16; cfg_width = 2'd0; cfg_vec = 1'b1; cfg_packed = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0;
        check("R10 ready low", int'(lk_ready), 0);
        lk_valid = 1'b1; lk_regs = {5'd0, 5'd0, 5'd14}; lk_used = 3'b001; lk_is_fp = 1'b0;
        @(negedge clk);
        check("R10 no response while busy", int'(rsp_valid), 0);
        lk_valid = 1'b0;
        repeat (2) @(negedge clk);
        check("R11 still busy before restart", int'(busy), 1);
        wr(7, 1'b0, 14, 24, 0, 1'b1, 1'b0, 1'b0, nb);
        check("R11 restart length", nb, NE + 1);
        look(1'b0, 14, 0, 0, 1);
        check("R11 later write in effect", reg_of(0), 24);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_vector;
        t_nonvec;
        t_fp;
        t_priority;
        t_used;
        t_bank;
        t_stall;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule